// File: doc/BRIEF.md
# Port-Pin External Interrupt Merger

This block turns an eight-bit general-purpose port and the dedicated active-low interrupt pin into the single external interrupt request of a small CPU. Each port pin has a fixed enable option. A pin joins the request only when its option is set and its data-direction bit makes it an input. The active-low pins that qualify are merged with the interrupt pin, so any one of them pulled low drives the merged line low. That merged line is also the status bit that the branch-on-interrupt-level instructions test. The dedicated pin is not exposed to them on its own.

A falling edge on the merged line sets a pending latch. The CPU sees that latch only while its interrupt mask bit is clear. The latch holds while the mask is set and clears when the external interrupt is acknowledged.

The software interrupt ignores the mask. The block captures, on the fetch of the software interrupt, whether an unmasked external interrupt was already waiting. If one was, the external vector is presented first. Otherwise the software vector comes first, and any external interrupt that arrives later waits behind it. One acknowledge input retires whichever vector is currently presented.

Top module: `port_irq_merge`

## Requirements
- R1: A port pin whose option bit in `pin_opt` is 0 has no effect on `irq_level` or on the pending request, whatever its level.
- R2: A port pin with its option set but its `pin_dir` bit at 1 (output) has no effect on `irq_level` or on the pending request.
- R3: `irq_level` is combinational. It is 0 exactly when `irq_n` is 0 or any enabled input pin (option 1, direction 0) is 0. Otherwise it is 1.
- R4: A 1-to-0 transition of the merged line, seen at a clock edge, sets the external pending latch at that edge. A level held low does not set the latch again after it has been acknowledged.
- R5: With `i_mask` at 1 and no software interrupt waiting, `irq_req` is 0. A latched external request survives the mask, and `irq_req` rises in the same cycle that `i_mask` returns to 0.
- R6: `ack` while the external vector is presented (`vec_sel` = 0) clears the external latch at that clock edge.
- R7: `swi_exec` together with `fetch_strobe` makes a software interrupt pending at that edge, whatever the value of `i_mask`. `irq_req` is then 1, with `vec_sel` = 1 and `vec_addr` = 0x1FFC.
- R8: If an unmasked external request is already pending at the software-interrupt fetch, the external vector (`vec_sel` = 0, `vec_addr` = 0x1FFA) is presented first. After its `ack`, the software vector is presented.
- R9: An external request that becomes pending after the software-interrupt fetch is presented only after the software interrupt has been acknowledged.
- R10: After reset, `irq_req` is 0 and no request is pending.

Encoding: `vec_sel` 0 selects the external pair 0x1FFA/0x1FFB and 1 selects the software pair 0x1FFC/0x1FFD. `vec_addr` gives the high-byte address. When no external vector is presented, it shows the software pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n | input | 1 | Dedicated active-low interrupt pin |
| pin_in | input | 8 | Port pin levels (idle high through pull-ups) |
| pin_opt | input | 8 | Static per-pin interrupt enable options |
| pin_dir | input | 8 | Data-direction bits, 1 = output |
| i_mask | input | 1 | CPU interrupt mask bit |
| swi_exec | input | 1 | Software interrupt instruction strobe |
| fetch_strobe | input | 1 | Instruction fetch boundary strobe |
| ack | input | 1 | Acknowledge of the presented vector |
| irq_req | output | 1 | Interrupt request to the CPU |
| vec_sel | output | 1 | 0 = external vector pair, 1 = software pair |
| vec_addr | output | 16 | High-byte address of the selected vector pair |
| irq_level | output | 1 | Merged pin level for the level-test instructions |

## Verification
`irq_level` depends only on the inputs and is sampled 1 ns after the inputs change. A change of the merged line reaches the pending latch at the next rising edge. `irq_req`, `vec_sel` and `vec_addr` are therefore checked at the falling edge after the edge that sees the change. The same one-edge delay applies after `ack` and after the software-interrupt fetch strobe. The mask acts combinationally on `irq_req`, so it is checked 1 ns after `i_mask` is driven. All stimulus is driven on falling edges, and every check is placed by counting these edges.

// File: rtl/port_irq_merge.sv
module port_irq_merge #(
  parameter int          NPIN    = 8,
  parameter logic [15:0] EXT_VEC = 16'h1FFA,
  parameter logic [15:0] SWI_VEC = 16'h1FFC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] pin_opt,
  input  logic [NPIN-1:0] pin_dir,
  input  logic            i_mask,
  input  logic            swi_exec,
  input  logic            fetch_strobe,
  input  logic            ack,
  output logic            irq_req,
  output logic            vec_sel,
  output logic [15:0]     vec_addr,
  output logic            irq_level
);

  logic [NPIN-1:0] pin_src;
  logic comb_n, level_q, ext_pend_q, swi_pend_q, hw_first_q;
  logic fall, ext_ok, take_ext, swi_fetch, ack_ext, ack_swi;

  assign pin_src   = pin_opt & ~pin_dir;
  assign comb_n    = irq_n & (&(pin_in | ~pin_src));
  assign irq_level = comb_n;

  assign fall      = level_q & ~comb_n;
  assign ext_ok    = ext_pend_q & ~i_mask;
  assign take_ext  = ext_ok & (~swi_pend_q | hw_first_q);
  assign swi_fetch = swi_exec & fetch_strobe;
  assign ack_ext   = ack & take_ext;
  assign ack_swi   = ack & ~take_ext & swi_pend_q;

  assign irq_req  = ext_ok | swi_pend_q;
  assign vec_sel  = ~take_ext;
  assign vec_addr = take_ext ? EXT_VEC : SWI_VEC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q    <= 1'b1;
      ext_pend_q <= 1'b0;
      swi_pend_q <= 1'b0;
      hw_first_q <= 1'b0;
    end else begin
      level_q <= comb_n;
      if (fall)         ext_pend_q <= 1'b1;
      else if (ack_ext) ext_pend_q <= 1'b0;
      if (swi_fetch)    swi_pend_q <= 1'b1;
      else if (ack_swi) swi_pend_q <= 1'b0;
      if (swi_fetch)                hw_first_q <= ext_ok;
      else if (ack_ext || ack_swi)  hw_first_q <= 1'b0;
    end
  end

endmodule

// File: rtl/port_irq_merge_chk.sv
module port_irq_merge_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_n,
  input logic i_mask,
  input logic swi_exec,
  input logic fetch_strobe,
  input logic ack,
  input logic irq_req,
  input logic vec_sel,
  input logic irq_level,
  input logic pend_q,
  input logic swi_q
);

  assert_pin_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> !irq_level);

  assert_fall_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_level) |=> pend_q);

  assert_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (i_mask && !swi_q) |-> !irq_req);

  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !vec_sel && irq_level) |=> !pend_q);

  assert_swi_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_exec && fetch_strobe) |=> irq_req);

endmodule

bind port_irq_merge port_irq_merge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .i_mask(i_mask),
  .swi_exec(swi_exec), .fetch_strobe(fetch_strobe), .ack(ack),
  .irq_req(irq_req), .vec_sel(vec_sel), .irq_level(irq_level),
  .pend_q(ext_pend_q), .swi_q(swi_pend_q)
);

// File: tb/test_port_irq_merge.sv
module test_port_irq_merge;
  logic clk = 1'b0, rst_n = 1'b0, irq_n = 1'b1;
  logic [7:0] pin_in = 8'hFF, pin_opt = 8'h00, pin_dir = 8'h00;
  logic i_mask = 1'b0, swi_exec = 1'b0, fetch_strobe = 1'b0, ack = 1'b0;
  logic irq_req, vec_sel, irq_level;
  logic [15:0] vec_addr;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  port_irq_merge i_port_irq_merge (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .pin_in(pin_in),
    .pin_opt(pin_opt), .pin_dir(pin_dir), .i_mask(i_mask),
    .swi_exec(swi_exec), .fetch_strobe(fetch_strobe), .ack(ack),
    .irq_req(irq_req), .vec_sel(vec_sel), .vec_addr(vec_addr),
    .irq_level(irq_level)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_vec(input string req, input bit ext);
    check(irq_req == 1'b1, req, irq_req, 1);
    check(vec_sel == !ext, req, vec_sel, !ext);
    check(vec_addr == (ext ? 16'h1FFA : 16'h1FFC), req, vec_addr, ext ? 16'h1FFA : 16'h1FFC);
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    check(irq_req == 1'b0, "R10", irq_req, 0);
    rst_n = 1'b1;
    step();
    check(irq_req == 1'b0, "R10", irq_req, 0);
    check(irq_level == 1'b1, "R10", irq_level, 1);

    // R1 R2 R3 sweep: every pin, every option/direction pair
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 4; c++) begin
        bit opt = c[0], dir = c[1], en;
        en = opt && !dir;
        pin_opt = 8'(opt) << p;
        pin_dir = 8'(dir) << p;
        step();
        check(irq_level == 1'b1, "R3", irq_level, 1);
        pin_in = ~(8'h01 << p);
        #1;
        check(irq_level == !en, !opt ? "R1" : (dir ? "R2" : "R3"), irq_level, !en);
        step();
        check(irq_req == en, !opt ? "R1" : (dir ? "R2" : "R4"), irq_req, en);
        if (en) begin
          do_ack();
          check(irq_req == 1'b0, "R6", irq_req, 0);
          step();
          check(irq_req == 1'b0, "R4", irq_req, 0);
        end
        pin_in = 8'hFF;
        step();
      end
    end
    pin_opt = 8'h00; pin_dir = 8'h00;

    // R5 mask holds a pending request
    i_mask = 1'b1; irq_n = 1'b0;
    step(); step(); step();
    check(irq_req == 1'b0, "R5", irq_req, 0);
    i_mask = 1'b0; #1;
    check(irq_req == 1'b1, "R5", irq_req, 1);
    step();
    do_ack();
    check(irq_req == 1'b0, "R6", irq_req, 0);
    irq_n = 1'b1; step();

    // R7 software interrupt under mask
    i_mask = 1'b1;
    swi_exec = 1'b1; fetch_strobe = 1'b1; step();
    swi_exec = 1'b0; fetch_strobe = 1'b0;
    chk_vec("R7", 1'b0);
    do_ack();
    check(irq_req == 1'b0, "R7", irq_req, 0);
    i_mask = 1'b0; step();

    // R8 external pending before the fetch goes first
    irq_n = 1'b0; step();
    chk_vec("R8", 1'b1);
    swi_exec = 1'b1; fetch_strobe = 1'b1; step();
    swi_exec = 1'b0; fetch_strobe = 1'b0;
    chk_vec("R8", 1'b1);
    do_ack();
    chk_vec("R8", 1'b0);
    do_ack();
    check(irq_req == 1'b0, "R8", irq_req, 0);
    irq_n = 1'b1; step();

    // R9 external arriving after the fetch waits
    swi_exec = 1'b1; fetch_strobe = 1'b1; step();
    swi_exec = 1'b0; fetch_strobe = 1'b0;
    irq_n = 1'b0; step();
    chk_vec("R9", 1'b0);
    do_ack();
    chk_vec("R9", 1'b1);
    do_ack();
    check(irq_req == 1'b0, "R9", irq_req, 0);
    irq_n = 1'b1; step();

    // fetch strobe alone does nothing
    fetch_strobe = 1'b1; step(); fetch_strobe = 1'b0;
    check(irq_req == 1'b0, "R7", irq_req, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule